// File: doc/BRIEF.md
# Acquire/Release Ordering Gate

This block sits between one thread's request stream and the memory system. It decides, for each request, whether it may leave for memory now or must wait. Every request carries a two-bit kind tag: ordinary access, full synchronization, acquire or release. A mode input picks one of two ordering disciplines. Weak ordering treats every non-ordinary request as a full fence. Release consistency lets an acquire overlap older ordinary accesses but hold back younger ones, and lets a release wait for older accesses while younger ones overtake it.

The gate keeps a small table of outstanding requests, one entry per 4-bit request id. An entry is allocated when a request is accepted and freed when a completion with that id arrives. Completions may come in any order. The same table enforces same-address ordering and the capacity limit, and it catches completions for ids that are not in use.

Top module: `ordering_gate`

## Requirements
- R1: After reset, out_valid and err_unknown are low, and in_ready is high whenever a request is offered.
- R2: Ordinary requests (kind 0) to distinct addresses are accepted while earlier ordinary requests are still outstanding, and their completions are accepted in any order.
- R3: With mode_rc=0, a request of kind 1 (sync), 2 (acquire) or 3 (release) is accepted only when no request is outstanding.
- R4: With mode_rc=0, while any request of kind 1, 2 or 3 is outstanding, no request of any kind is accepted.
- R5: With mode_rc=1, an acquire (kind 2) is accepted while ordinary requests are outstanding, and while an acquire is outstanding no request is accepted.
- R6: With mode_rc=1, a release (kind 3) is accepted only when nothing is outstanding, and ordinary requests and acquires are accepted while a release is outstanding.
- R7: With mode_rc=1, a sync (kind 1) waits for all outstanding requests, and no request is accepted while it is outstanding.
- R8: A request is not accepted while an outstanding request has the same address, in either mode.
- R9: With 16 requests outstanding, no request is accepted.
- R10: Each accepted request gets the lowest-numbered free id, shown on out_id.
- R11: A completion whose id is not outstanding sets err_unknown, which stays high until reset, and it frees no entry.
- R12: The output register holds out_valid, out_kind, out_addr and out_id unchanged until out_ready is seen, and in_ready is low while out_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_rc | input | 1 | 0 = weak ordering, 1 = release consistency |
| in_valid | input | 1 | Request offered |
| in_kind | input | 2 | 0 ordinary, 1 sync, 2 acquire, 3 release |
| in_addr | input | 8 | Request address |
| in_ready | output | 1 | Request accepted this cycle when in_valid is high |
| out_valid | output | 1 | Request waiting for memory |
| out_kind | output | 2 | Kind of the issued request |
| out_addr | output | 8 | Address of the issued request |
| out_id | output | 4 | Id assigned to the issued request |
| out_ready | input | 1 | Memory takes the issued request |
| cpl_valid | input | 1 | Completion strobe |
| cpl_id | input | 4 | Id of the completing request |
| err_unknown | output | 1 | Sticky flag for a completion with an unused id |

## Verification
The hardest situation to reach is a full table with a freed hole in the middle. Only then can the bench show that allocation picks the lowest free id and not the next one in sequence, and that a 17th request stalls. The bench fills all 16 entries with ordinary requests to distinct addresses, completes one id in the middle, and checks that the next request takes that id. Every pairing of an older outstanding kind and a newer kind is also swept in both modes, with each accept or stall decision worked out from the ordering rules.

// File: rtl/ogate_pkg.sv
package ogate_pkg;
  typedef enum logic [1:0] {
    K_PLAIN = 2'd0,
    K_SYNC  = 2'd1,
    K_ACQ   = 2'd2,
    K_REL   = 2'd3
  } kind_e;
endpackage

// File: rtl/ogate_table.sv
module ogate_table #(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc,
  input  logic [1:0]        alloc_kind,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              cpl_valid,
  input  logic [ID_W-1:0]   cpl_id,
  input  logic [ADDR_W-1:0] q_addr,
  output logic [ID_W-1:0]   free_id,
  output logic              full,
  output logic              any_occ,
  output logic              acq_pend,
  output logic              sync_pend,
  output logic              rel_pend,
  output logic              addr_hit,
  output logic              bad_cpl
);
  import ogate_pkg::*;
  localparam int NENT = 1 << ID_W;

  logic [NENT-1:0]   occ;
  logic [1:0]        ent_kind [NENT];
  logic [ADDR_W-1:0] ent_addr [NENT];
  logic [NENT-1:0]   is_acq, is_sync, is_rel, hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      occ <= '0;
    end else begin
      for (int i = 0; i < NENT; i++) begin
        if (alloc && free_id == ID_W'(i)) begin
          occ[i]      <= 1'b1;
          ent_kind[i] <= alloc_kind;
          ent_addr[i] <= alloc_addr;
        end else if (cpl_valid && cpl_id == ID_W'(i)) begin
          occ[i] <= 1'b0;
        end
      end
    end
  end

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    assign is_acq[g]  = occ[g] && ent_kind[g] == K_ACQ;
    assign is_sync[g] = occ[g] && ent_kind[g] == K_SYNC;
    assign is_rel[g]  = occ[g] && ent_kind[g] == K_REL;
    assign hit[g]     = occ[g] && ent_addr[g] == q_addr;
  end

  always_comb begin
    free_id = '0;
    for (int i = NENT - 1; i >= 0; i--)
      if (!occ[i]) free_id = ID_W'(i);
  end

  assign full      = &occ;
  assign any_occ   = |occ;
  assign acq_pend  = |is_acq;
  assign sync_pend = |is_sync;
  assign rel_pend  = |is_rel;
  assign addr_hit  = |hit;
  assign bad_cpl   = cpl_valid && !occ[cpl_id];
endmodule

// File: rtl/ogate_rules.sv
module ogate_rules (
  input  logic       mode_rc,
  input  logic [1:0] kind,
  input  logic       any_occ,
  input  logic       acq_pend,
  input  logic       sync_pend,
  input  logic       rel_pend,
  input  logic       addr_hit,
  input  logic       full,
  output logic       allow
);
  import ogate_pkg::*;
  logic order_ok;

  always_comb begin
    if (!mode_rc) begin
      // weak ordering: every non-ordinary kind is a two-sided fence
      if (acq_pend || sync_pend || rel_pend) order_ok = 1'b0;
      else if (kind == K_PLAIN)              order_ok = 1'b1;
      else                                   order_ok = !any_occ;
    end else begin
      // release consistency: acquire and sync block younger requests
      if (acq_pend || sync_pend) order_ok = 1'b0;
      else begin
        unique case (kind)
          K_PLAIN, K_ACQ: order_ok = 1'b1;
          default:        order_ok = !any_occ;
        endcase
      end
    end
    allow = order_ok && !addr_hit && !full;
  end
endmodule

// File: rtl/ordering_gate.sv
module ordering_gate #(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_rc,
  input  logic              in_valid,
  input  logic [1:0]        in_kind,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              in_ready,
  output logic              out_valid,
  output logic [1:0]        out_kind,
  output logic [ADDR_W-1:0] out_addr,
  output logic [ID_W-1:0]   out_id,
  input  logic              out_ready,
  input  logic              cpl_valid,
  input  logic [ID_W-1:0]   cpl_id,
  output logic              err_unknown
);
  logic [ID_W-1:0] free_id;
  logic full, any_occ, acq_pend, sync_pend, rel_pend, addr_hit, bad_cpl;
  logic allow, accept;

  ogate_table #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_tab (
    .clk(clk), .rst(rst),
    .alloc(accept), .alloc_kind(in_kind), .alloc_addr(in_addr),
    .cpl_valid(cpl_valid), .cpl_id(cpl_id), .q_addr(in_addr),
    .free_id(free_id), .full(full), .any_occ(any_occ),
    .acq_pend(acq_pend), .sync_pend(sync_pend), .rel_pend(rel_pend),
    .addr_hit(addr_hit), .bad_cpl(bad_cpl)
  );

  ogate_rules u_rules (
    .mode_rc(mode_rc), .kind(in_kind), .any_occ(any_occ),
    .acq_pend(acq_pend), .sync_pend(sync_pend), .rel_pend(rel_pend),
    .addr_hit(addr_hit), .full(full), .allow(allow)
  );

  assign in_ready = !out_valid && allow;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_kind  <= '0;
      out_addr  <= '0;
      out_id    <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_kind  <= in_kind;
      out_addr  <= in_addr;
      out_id    <= free_id;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err_unknown <= 1'b0;
    else if (bad_cpl) err_unknown <= 1'b1;
  end
endmodule

// File: rtl/ogate_chk.sv
module ogate_chk #(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_rc,
  input logic              in_valid,
  input logic [1:0]        in_kind,
  input logic              in_ready,
  input logic              out_valid,
  input logic [1:0]        out_kind,
  input logic [ADDR_W-1:0] out_addr,
  input logic [ID_W-1:0]   out_id,
  input logic              out_ready,
  input logic              cpl_valid,
  input logic [ID_W-1:0]   cpl_id,
  input logic              err_unknown
);
  localparam int NENT = 1 << ID_W;
  logic [NENT-1:0] shadow;

  always_ff @(posedge clk) begin
    if (rst) shadow <= '0;
    else begin
      if (cpl_valid) shadow[cpl_id] <= 1'b0;
      if (out_valid && out_ready) shadow[out_id] <= 1'b1;
    end
  end

  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_id) && $stable(out_kind) && $stable(out_addr));
  // R12
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> $countones(shadow) < NENT);
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_unknown |=> err_unknown);
  // R11
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_unknown) |-> $past(cpl_valid && !shadow[cpl_id]));
  // R3
  weak_fence_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_rc && in_valid && in_ready && in_kind != 2'd0 |-> shadow == '0);
  // R6
  rel_drain_chk: assert property (@(posedge clk) disable iff (rst)
    mode_rc && in_valid && in_ready && in_kind == 2'd3 |-> shadow == '0);
endmodule

bind ordering_gate ogate_chk #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .mode_rc(mode_rc), .in_valid(in_valid),
  .in_kind(in_kind), .in_ready(in_ready), .out_valid(out_valid),
  .out_kind(out_kind), .out_addr(out_addr), .out_id(out_id),
  .out_ready(out_ready), .cpl_valid(cpl_valid), .cpl_id(cpl_id),
  .err_unknown(err_unknown)
);

// File: tb/tb_ordering_gate.sv
module tb_ordering_gate;
  logic clk = 1'b0;
  logic rst, mode_rc, in_valid, out_ready, cpl_valid;
  logic [1:0] in_kind;
  logic [7:0] in_addr;
  logic [3:0] cpl_id;
  logic in_ready, out_valid, err_unknown;
  logic [1:0] out_kind;
  logic [7:0] out_addr;
  logic [3:0] out_id;

  int vectors = 0;
  int fails = 0;
  logic [15:0] occ_m;

  always #10 clk = ~clk;

  ordering_gate dut (
    .clk(clk), .rst(rst), .mode_rc(mode_rc), .in_valid(in_valid),
    .in_kind(in_kind), .in_addr(in_addr), .in_ready(in_ready),
    .out_valid(out_valid), .out_kind(out_kind), .out_addr(out_addr),
    .out_id(out_id), .out_ready(out_ready), .cpl_valid(cpl_valid),
    .cpl_id(cpl_id), .err_unknown(err_unknown)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string rq);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [3:0] low_free();
    for (int i = 15; i >= 0; i--) ;
    for (int i = 0; i < 16; i++) if (!occ_m[i]) return 4'(i);
    return 4'd0;
  endfunction

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst = 1; mode_rc = m; in_valid = 0; in_kind = 0; in_addr = 0;
    out_ready = 0; cpl_valid = 0; cpl_id = 0;
    repeat (2) @(posedge clk);
    #1 rst = 0; occ_m = '0;
    @(negedge clk); #1;
    chk(in_ready, 1, "R1 in_ready"); chk(out_valid, 0, "R1 out_valid");
    chk(err_unknown, 0, "R1 err");
  endtask

  task automatic try_req(input logic [1:0] k, input logic [7:0] a, input logic exp, input string rq);
    logic [3:0] eid;
    @(negedge clk);
    in_valid = 1; in_kind = k; in_addr = a; #1;
    chk(in_ready, exp, rq);
    if (in_ready) begin
      eid = low_free();
      @(posedge clk); #1;
      in_valid = 0;
      chk(out_valid, 1, rq); chk(out_id, eid, {rq, " R10 id"});
      chk(out_kind, k, rq); chk(out_addr, a, rq);
      occ_m[eid] = 1'b1;
      out_ready = 1;
      @(posedge clk); #1;
      out_ready = 0;
    end else begin
      in_valid = 0;
    end
  endtask

  task automatic complete(input logic [3:0] id);
    @(negedge clk);
    cpl_valid = 1; cpl_id = id;
    @(posedge clk); #1;
    cpl_valid = 0;
    occ_m[id] = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 16; i++) if (occ_m[i]) complete(4'(i));
  endtask

  function automatic logic expect_pair(input logic m, input logic [1:0] a, input logic [1:0] b);
    if (!m) return (a == 0) && (b == 0);
    if (a == 1 || a == 2) return 1'b0;
    return (b == 0) || (b == 2);
  endfunction

  function automatic string pair_tag(input logic m, input logic [1:0] a, input logic [1:0] b);
    if (!m) begin
      if (a != 0) return "R4 weak older fence";
      if (b != 0) return "R3 weak newer fence";
      return "R2 overlap";
    end
    if (a == 2 || b == 2) return "R5 acquire";
    if (a == 1 || b == 1) return "R7 rc sync";
    if (a == 3 || b == 3) return "R6 release";
    return "R2 overlap";
  endfunction

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic e;
    // sweep of older-kind / newer-kind pairs in both modes
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 4; a++) begin
        for (int b = 0; b < 4; b++) begin
          do_reset(1'(m));
          try_req(2'(a), 8'h10, 1'b1, "R2 first");
          e = expect_pair(1'(m), 2'(a), 2'(b));
          try_req(2'(b), 8'h20, e, pair_tag(1'(m), 2'(a), 2'(b)));
          complete(4'd0);
          if (!e) try_req(2'(b), 8'h20, 1'b1, pair_tag(1'(m), 2'(a), 2'(b)));
          drain();
        end
      end
    end

    // R2 out-of-order completions then reuse
    do_reset(1'b0);
    try_req(0, 8'h01, 1, "R2"); try_req(0, 8'h02, 1, "R2"); try_req(0, 8'h03, 1, "R2");
    complete(4'd2); complete(4'd0);
    try_req(0, 8'h04, 1, "R2 after ooo");
    chk(err_unknown, 0, "R2 no error on ooo completions");
    drain();

    // R8 same address in both modes
    for (int m = 0; m < 2; m++) begin
      do_reset(1'(m));
      try_req(0, 8'h55, 1, "R8");
      try_req(0, 8'h55, 0, "R8 same addr");
      try_req(0, 8'h56, 1, "R8 other addr");
      complete(4'd0);
      try_req(0, 8'h55, 1, "R8 after completion");
      drain();
    end

    // R9 full table, R10 hole reuse
    do_reset(1'b1);
    for (int i = 0; i < 16; i++) try_req(0, 8'(8'h80 + i), 1, "R9 fill");
    try_req(0, 8'h40, 0, "R9 full");
    complete(4'd7);
    try_req(0, 8'h41, 1, "R10 hole");
    try_req(0, 8'h42, 0, "R9 full again");
    drain();

    // R11 unknown completion leaves table unchanged
    do_reset(1'b0);
    try_req(0, 8'h11, 1, "R11 setup");
    complete(4'd5); occ_m[5] = 1'b0;
    chk(err_unknown, 1, "R11 flag");
    try_req(0, 8'h12, 1, "R11 next id");
    try_req(0, 8'h11, 0, "R11 entry 0 kept");
    repeat (3) @(posedge clk);
    #1 chk(err_unknown, 1, "R11 sticky");
    drain();

    // R12 hold while memory stalls
    do_reset(1'b1);
    @(negedge clk);
    in_valid = 1; in_kind = 2; in_addr = 8'h33;
    @(posedge clk); #1;
    in_valid = 0; in_kind = 0; in_addr = 8'h34;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #1;
      chk(out_valid, 1, "R12 hold valid"); chk(out_kind, 2, "R12 hold kind");
      chk(out_addr, 8'h33, "R12 hold addr"); chk(in_ready, 0, "R12 ready low");
    end
    out_ready = 1;
    @(posedge clk); #1;
    out_ready = 0; occ_m[0] = 1'b1;
    @(negedge clk); #1;
    chk(out_valid, 0, "R12 released");
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule